// File: doc/BRIEF.md
# Egress Shim Header Parser

This block sits on the egress side of a line card. It takes frames arriving from the internal switch as a byte stream, one byte per accepted cycle, and parses the fixed switch header that comes before the meta frame. The first 12 bytes are the Ethernet destination and source addresses. Next comes an 802.1Q tag, whose 16-bit tag control word names the meta router. Then come the substrate EtherType, the transmit meta-interface, the source processing-engine id, the meta frame length and a 16-bit shim flags word. A shim data field of 0 to 63 bytes follows, and after it the meta frame.

For each frame the block produces exactly one of two results. The first is a header-done pulse. It carries a 32-bit lookup key, the decoded shim kind and size, the left-aligned shim data, the meta frame length, the source engine id and the byte offset at which the meta frame starts. The second is a drop pulse with a cause code. A drop happens when the tag, the EtherType or the shim kind is not acceptable on a line card. A saturating counter records the drops. Bytes that follow the header are ignored until the next start of frame.

Top module: `egr_shim_parser`

## Requirements
- R1: After reset `hdr_done`, `shim_vld` and `drop_pulse` are low and `drop_count` is zero.
- R2: `lkup_key` equals {tag control word, TxMI}. The tag control word is frame bytes 14..15, placed in key bits 31:16. The TxMI is frame bytes 18..19, placed in key bits 15:0. Each word is big-endian, with the earlier byte as the high byte.
- R3: If bytes 12..13 are not 0x8100, the frame is dropped with `drop_cause`=1. The drop pulse appears in the cycle after byte 13 is accepted.
- R4: If bytes 16..17 are not the `SUBST_ETYPE` parameter (default 0x88B6), the frame is dropped with `drop_cause`=2. The drop pulse appears in the cycle after byte 17 is accepted.
- R5: The flags word is bytes 24..25. Its bits 15:14 give the shim kind: 0 no next hop, 1 next-hop meta address, 2 MAC address, 3 engine-to-engine. Its bits 5:0 give the shim size in bytes, and its bits 13:6 are ignored. Kind 3 drops the frame with `drop_cause`=3 in the cycle after byte 25, and no `hdr_done` follows.
- R6: `hdr_done` pulses for one cycle, in the cycle after the last header byte is accepted. The last header byte is byte 25 when the size is 0, and byte 25+size otherwise. With the pulse, `shim_kind`, `shim_size`, `meta_len` (bytes 22..23), `src_engine` (bytes 20..21) and `meta_off` = 26 + size are all valid.
- R7: Shim byte j (frame byte 26+j) appears at `shim_data[503-8j -: 8]`. Bytes at or beyond the size read as zero. `shim_vld` pulses together with `hdr_done` only when the size is non-zero.
- R8: `drop_count` increases by one on each drop pulse, holds otherwise, and saturates at all ones.
- R9: A cycle with `in_vld` low is ignored, whatever `in_sof` and `in_byte` carry. After a frame's done or drop pulse, further bytes produce nothing until a byte with `in_sof` high is accepted.
- R10: An accepted byte with `in_sof` high is byte 0 of a new frame, even if the previous header was incomplete. The partial frame produces no result.
- R11: `hdr_done` and `drop_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Byte on `in_byte` is valid this cycle |
| in_sof | input | 1 | Valid byte is the first byte of a frame |
| in_byte | input | 8 | Frame byte |
| hdr_done | output | 1 | Header parsed; result fields valid |
| lkup_key | output | 32 | {tag control word, TxMI} |
| shim_kind | output | 2 | Decoded shim kind |
| shim_size | output | 6 | Shim data length in bytes |
| meta_off | output | 8 | Byte offset of the meta frame |
| meta_len | output | 16 | Meta frame length field |
| src_engine | output | 16 | Source processing-engine id |
| shim_vld | output | 1 | Shim data present (size non-zero) |
| shim_data | output | 504 | Shim bytes, left-aligned |
| drop_pulse | output | 1 | Frame dropped |
| drop_cause | output | 2 | 1 bad tag, 2 bad EtherType, 3 engine shim |
| drop_count | output | DROP_CNT_W | Saturating drop counter |

## Verification
The bench builds the parser with `DROP_CNT_W`=3. With that width, a run of nine rejected frames drives the counter into saturation, so the hold-at-all-ones behaviour can be observed at the port. `SUBST_ETYPE` stays at its default. The shim size field spans its full range, so frames carry shim lengths of 0, 3, 4, 6 and the maximum of 63 bytes. Along the way the frames cross stall cycles in which `in_sof` is raised while `in_vld` is low.

// File: rtl/egr_shim_pkg.sv
package egr_shim_pkg;

    // Byte positions fixed by the frame layout
    localparam int HDR_FIXED   = 26;
    localparam int WORD_BASE   = 12;
    localparam int NUM_WORDS   = 7;
    localparam int SIZE_W      = 6;
    localparam int SHIM_BYTES  = (1 << SIZE_W) - 1;
    localparam int MAX_IDX     = HDR_FIXED + SHIM_BYTES;
    localparam int IDX_W       = $clog2(MAX_IDX + 1);
    localparam int OFF_W       = 8;

    localparam logic [15:0] TAG_TPID = 16'h8100;

    // Word slots inside the captured header window
    localparam int W_TPID = 0;
    localparam int W_TCI  = 1;
    localparam int W_ETY  = 2;
    localparam int W_TXMI = 3;
    localparam int W_ENG  = 4;
    localparam int W_LEN  = 5;
    localparam int W_FLG  = 6;

    localparam int IDX_TAG_LO = WORD_BASE + 2 * W_TPID + 1;
    localparam int IDX_ETY_LO = WORD_BASE + 2 * W_ETY + 1;
    localparam int IDX_FLG_LO = WORD_BASE + 2 * W_FLG + 1;

    typedef enum logic [1:0] {
        SHIM_NONE    = 2'b00,
        SHIM_NH_ADDR = 2'b01,
        SHIM_MAC     = 2'b10,
        SHIM_ENGINE  = 2'b11
    } shim_kind_e;

    typedef enum logic [1:0] {
        DROP_NONE   = 2'd0,
        DROP_TAG    = 2'd1,
        DROP_ETYPE  = 2'd2,
        DROP_ENGINE = 2'd3
    } drop_why_e;

    typedef struct packed {
        shim_kind_e          kind;
        logic [SIZE_W-1:0]   size;
    } shim_flags_t;

    function automatic shim_flags_t decode_flags(input logic [15:0] w);
        shim_flags_t f;
        f.kind = shim_kind_e'(w[15:14]);
        f.size = w[SIZE_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/egr_hdr_words.sv
module egr_hdr_words
    import egr_shim_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        take,
    input  logic [IDX_W-1:0]            idx,
    input  logic [7:0]                  din,
    output logic [NUM_WORDS-1:0][15:0]  word_q
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(WORD_BASE + 2 * w);
        localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(WORD_BASE + 2 * w + 1);
        logic [15:0] w_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                w_q <= '0;
            end else if (take) begin
                if (idx == HI_IDX) w_q[15:8] <= din;
                if (idx == LO_IDX) w_q[7:0]  <= din;
            end
        end

        assign word_q[w] = w_q;
    end

endmodule

// File: rtl/egr_shim_store.sv
module egr_shim_store
    import egr_shim_pkg::*;
#(
    parameter int NBYTES = SHIM_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  take,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            din,
    output logic [NBYTES*8-1:0]   shim_q
);

    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(HDR_FIXED + j);
        logic [7:0] b_q;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                b_q <= '0;
            end else if (take && idx == MY_IDX) begin
                b_q <= din;
            end
        end

        assign shim_q[NBYTES*8-1-8*j -: 8] = b_q;
    end

endmodule

// File: rtl/egr_shim_parser.sv
module egr_shim_parser
    import egr_shim_pkg::*;
#(
    parameter logic [15:0] SUBST_ETYPE = 16'h88B6,
    parameter int          DROP_CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic                     in_sof,
    input  logic [7:0]               in_byte,
    output logic                     hdr_done,
    output logic [31:0]              lkup_key,
    output logic [1:0]               shim_kind,
    output logic [SIZE_W-1:0]        shim_size,
    output logic [OFF_W-1:0]         meta_off,
    output logic [15:0]              meta_len,
    output logic [15:0]              src_engine,
    output logic                     shim_vld,
    output logic [SHIM_BYTES*8-1:0]  shim_data,
    output logic                     drop_pulse,
    output logic [1:0]               drop_cause,
    output logic [DROP_CNT_W-1:0]    drop_count
);

    localparam logic [IDX_W-1:0] TAG_LAST = IDX_W'(IDX_TAG_LO);
    localparam logic [IDX_W-1:0] ETY_LAST = IDX_W'(IDX_ETY_LO);
    localparam logic [IDX_W-1:0] FLG_LAST = IDX_W'(IDX_FLG_LO);

    // Frame position tracking
    logic                 active_q;
    logic [IDX_W-1:0]     pos_q;
    logic                 take;
    logic [IDX_W-1:0]     idx;

    assign take = in_vld && (in_sof || active_q);
    assign idx  = in_sof ? '0 : pos_q;

    // Captured header words
    logic [NUM_WORDS-1:0][15:0] word_q;

    egr_hdr_words u_words (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .idx    (idx),
        .din    (in_byte),
        .word_q (word_q)
    );

    egr_shim_store #(.NBYTES(SHIM_BYTES)) u_shim (
        .clk    (clk),
        .rst    (rst),
        .clear  (take && in_sof),
        .take   (take),
        .idx    (idx),
        .din    (in_byte),
        .shim_q (shim_data)
    );

    // Checks against the word completing this cycle
    logic [15:0]  tag_now, ety_now, flg_now;
    shim_flags_t  flags_now, flags_reg, flags_sel;
    logic         at_flags, tag_bad, ety_bad, eng_bad, drop_hit, end_hit;
    drop_why_e    why_now;

    assign tag_now   = {word_q[W_TPID][15:8], in_byte};
    assign ety_now   = {word_q[W_ETY][15:8],  in_byte};
    assign flg_now   = {word_q[W_FLG][15:8],  in_byte};
    assign flags_now = decode_flags(flg_now);
    assign flags_reg = decode_flags(word_q[W_FLG]);

    assign at_flags  = take && idx == FLG_LAST;
    assign flags_sel = at_flags ? flags_now : flags_reg;

    assign tag_bad   = take && idx == TAG_LAST && tag_now != TAG_TPID;
    assign ety_bad   = take && idx == ETY_LAST && ety_now != SUBST_ETYPE;
    assign eng_bad   = at_flags && flags_now.kind == SHIM_ENGINE;
    assign drop_hit  = tag_bad || ety_bad || eng_bad;

    assign end_hit   = (at_flags && flags_now.kind != SHIM_ENGINE && flags_now.size == '0)
                    || (take && idx > FLG_LAST
                        && idx == FLG_LAST + IDX_W'(flags_reg.size));

    always_comb begin
        why_now = DROP_NONE;
        if (tag_bad)      why_now = DROP_TAG;
        else if (ety_bad) why_now = DROP_ETYPE;
        else if (eng_bad) why_now = DROP_ENGINE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pos_q    <= '0;
        end else if (take) begin
            pos_q    <= idx + 1'b1;
            active_q <= !(end_hit || drop_hit);
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_done   <= 1'b0;
            shim_vld   <= 1'b0;
            drop_pulse <= 1'b0;
            drop_cause <= DROP_NONE;
            drop_count <= '0;
            lkup_key   <= '0;
            shim_kind  <= SHIM_NONE;
            shim_size  <= '0;
            meta_off   <= '0;
            meta_len   <= '0;
            src_engine <= '0;
        end else begin
            hdr_done   <= end_hit;
            shim_vld   <= end_hit && flags_sel.size != '0;
            drop_pulse <= drop_hit;
            if (end_hit) begin
                lkup_key   <= {word_q[W_TCI], word_q[W_TXMI]};
                shim_kind  <= flags_sel.kind;
                shim_size  <= flags_sel.size;
                meta_off   <= OFF_W'(HDR_FIXED) + OFF_W'(flags_sel.size);
                meta_len   <= word_q[W_LEN];
                src_engine <= word_q[W_ENG];
            end
            if (drop_hit) begin
                drop_cause <= why_now;
                if (drop_count != '1) drop_count <= drop_count + 1'b1;
            end
        end
    end

    // R11
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(hdr_done && drop_pulse));

    // R5
    no_engine_done_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_done |-> shim_kind != SHIM_ENGINE);

    // R7
    shim_vld_chk: assert property (@(posedge clk) disable iff (rst)
        shim_vld |-> (hdr_done && shim_size != '0));

    // R6
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_done |=> !hdr_done);

    // R8
    drop_cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> (drop_count == $past(drop_count) + 1'b1
                        || ($past(drop_count) == '1 && drop_count == '1)));

    // R8
    drop_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !drop_pulse |-> $stable(drop_count));

    // R3
    drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> drop_cause != DROP_NONE);

endmodule

// File: tb/egr_shim_parser_tb.sv
`timescale 1ns/1ps
module egr_shim_parser_tb_top;

    localparam int CW = 3;
    localparam logic [15:0] SUBST = 16'h88B6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic          in_sof = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          hdr_done, shim_vld, drop_pulse;
    logic [31:0]   lkup_key;
    logic [1:0]    shim_kind, drop_cause;
    logic [5:0]    shim_size;
    logic [7:0]    meta_off;
    logic [15:0]   meta_len, src_engine;
    logic [503:0]  shim_data;
    logic [CW-1:0] drop_count;

    always #2.5 clk = ~clk;

    egr_shim_parser #(.SUBST_ETYPE(SUBST), .DROP_CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_sof(in_sof), .in_byte(in_byte),
        .hdr_done(hdr_done), .lkup_key(lkup_key), .shim_kind(shim_kind),
        .shim_size(shim_size), .meta_off(meta_off), .meta_len(meta_len),
        .src_engine(src_engine), .shim_vld(shim_vld), .shim_data(shim_data),
        .drop_pulse(drop_pulse), .drop_cause(drop_cause), .drop_count(drop_count)
    );

    typedef struct packed {
        logic         is_drop;
        logic [1:0]   cause;
        logic [31:0]  key;
        logic [1:0]   kind;
        logic [5:0]   size;
        logic [7:0]   off;
        logic [15:0]  len;
        logic [15:0]  eng;
        logic [503:0] shim;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   n_drops = 0;
    bit   finished = 1'b0;

    task automatic check(input string req, input logic [503:0] act, input logic [503:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    // Monitor: pops one expectation per result pulse
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (hdr_done || drop_pulse)) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R11 exclusive", hdr_done && drop_pulse, 0);
                    if (e.is_drop) begin
                        check("R3_R4_R5 drop pulse", drop_pulse, 1);
                        if (e.cause == 2'd1)      check("R3 cause", drop_cause, e.cause);
                        else if (e.cause == 2'd2) check("R4 cause", drop_cause, e.cause);
                        else                      check("R5 cause", drop_cause, e.cause);
                    end else begin
                        check("R6 done pulse", hdr_done, 1);
                        check("R2 key", lkup_key, e.key);
                        check("R5 kind", shim_kind, e.kind);
                        check("R5 size", shim_size, e.size);
                        check("R6 offset", meta_off, e.off);
                        check("R6 length", meta_len, e.len);
                        check("R6 engine", src_engine, e.eng);
                        check("R7 shim valid", shim_vld, e.size != 0);
                        check("R7 shim data", shim_data, e.shim);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] shim_byte(input int j, input logic [15:0] txmi);
        return 8'hA0 ^ 8'(j) ^ txmi[7:0];
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_vld = 1'b0; in_sof = 1'b0; in_byte = 8'hEE;
            @(posedge clk); #1;
        end
    endtask

    // Driver: builds a frame, records the expectation, streams its bytes
    task automatic send_frame(input logic [15:0] tpid, input logic [15:0] tci,
                              input logic [15:0] ety, input logic [15:0] txmi,
                              input logic [15:0] eng, input logic [15:0] mlen,
                              input logic [15:0] flags, input int npay,
                              input int stall_every, input int cut);
        logic [7:0] fb[$];
        int sz, nsend;
        exp_t e;
        sz = int'(flags[5:0]);
        for (int i = 0; i < 6; i++) fb.push_back(8'h10 + 8'(i));
        for (int i = 0; i < 6; i++) fb.push_back(8'h20 + 8'(i));
        fb.push_back(tpid[15:8]); fb.push_back(tpid[7:0]);
        fb.push_back(tci[15:8]);  fb.push_back(tci[7:0]);
        fb.push_back(ety[15:8]);  fb.push_back(ety[7:0]);
        fb.push_back(txmi[15:8]); fb.push_back(txmi[7:0]);
        fb.push_back(eng[15:8]);  fb.push_back(eng[7:0]);
        fb.push_back(mlen[15:8]); fb.push_back(mlen[7:0]);
        fb.push_back(flags[15:8]); fb.push_back(flags[7:0]);
        for (int j = 0; j < sz; j++) fb.push_back(shim_byte(j, txmi));
        for (int p = 0; p < npay; p++) fb.push_back((p % 2 == 0) ? 8'h81 : 8'h00);

        if (cut < 0) begin
            e = '0;
            if (tpid != 16'h8100) begin
                e.is_drop = 1; e.cause = 2'd1;
            end else if (ety != SUBST) begin
                e.is_drop = 1; e.cause = 2'd2;
            end else if (flags[15:14] == 2'b11) begin
                e.is_drop = 1; e.cause = 2'd3;
            end else begin
                e.key  = {tci, txmi};
                e.kind = flags[15:14];
                e.size = flags[5:0];
                e.off  = 8'(26 + sz);
                e.len  = mlen;
                e.eng  = eng;
                for (int j = 0; j < sz; j++) e.shim[503 - 8*j -: 8] = shim_byte(j, txmi);
            end
            if (e.is_drop) n_drops++;
            exp_q.push_back(e);
        end

        nsend = (cut < 0) ? fb.size() : cut;
        for (int k = 0; k < nsend; k++) begin
            if (stall_every > 0 && (k % stall_every) == stall_every - 1) begin
                // R9: in_sof raised with in_vld low must be ignored
                in_vld = 1'b0; in_sof = 1'b1; in_byte = 8'h81;
                @(posedge clk); #1;
            end
            in_vld = 1'b1; in_sof = (k == 0); in_byte = fb[k];
            @(posedge clk); #1;
        end
        idle(3);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 done low", hdr_done, 0);
        check("R1 drop low", drop_pulse, 0);
        check("R1 shim_vld low", shim_vld, 0);
        check("R1 count zero", drop_count, 0);
        @(posedge clk); #1;

        // R6 pass-through: flags zero
        send_frame(16'h8100, 16'h0123, SUBST, 16'h4567, 16'h0009, 16'd64, 16'h0000, 6, 0, -1);
        // R5 next-hop address, size 4, with stalls
        send_frame(16'h8100, 16'hBEEF, SUBST, 16'h0102, 16'h0A0B, 16'd100, 16'h4004, 5, 3, -1);
        // R5 MAC address, size 6
        send_frame(16'h8100, 16'h0FFF, SUBST, 16'hFFFF, 16'h1234, 16'd46, 16'h8006, 4, 0, -1);
        // R7 maximum shim size
        send_frame(16'h8100, 16'h7001, SUBST, 16'h00C3, 16'h5555, 16'd1500, 16'h003F, 3, 5, -1);
        // R5 ignored middle bits: kind 1, size 3
        send_frame(16'h8100, 16'h2222, SUBST, 16'h3333, 16'h4444, 16'd80, 16'h7FC3, 2, 0, -1);
        // R3 bad tag
        send_frame(16'h88A8, 16'h0001, SUBST, 16'h0002, 16'h0003, 16'd60, 16'h0000, 4, 0, -1);
        // R4 bad EtherType
        send_frame(16'h8100, 16'h0001, 16'h0800, 16'h0002, 16'h0003, 16'd60, 16'h0000, 4, 2, -1);
        // R5 engine shim dropped, shim bytes after it ignored (R9)
        send_frame(16'h8100, 16'h0005, SUBST, 16'h0006, 16'h0007, 16'd60, 16'hC005, 4, 0, -1);
        @(negedge clk);
        check("R8 count after three drops", drop_count, 3'd3);
        @(posedge clk); #1;

        // R10 truncated header then a fresh frame
        send_frame(16'h8100, 16'h0AAA, SUBST, 16'h0BBB, 16'h0CCC, 16'd10, 16'h0000, 0, 0, 15);
        send_frame(16'h8100, 16'h0DDD, SUBST, 16'h0EEE, 16'h0F0F, 16'd77, 16'h8002, 2, 0, -1);

        // R8 saturation: six more drops
        for (int d = 0; d < 6; d++) begin
            if (d % 3 == 0)
                send_frame(16'h9100, 16'(d), SUBST, 16'h0001, 16'h0002, 16'd60, 16'h0000, 1, 0, -1);
            else if (d % 3 == 1)
                send_frame(16'h8100, 16'(d), 16'h86DD, 16'h0001, 16'h0002, 16'd60, 16'h0000, 1, 0, -1);
            else
                send_frame(16'h8100, 16'(d), SUBST, 16'h0001, 16'h0002, 16'd60, 16'hC000, 1, 0, -1);
        end
        @(negedge clk);
        check("R8 saturated count", drop_count, (n_drops > 7) ? 3'd7 : 3'(n_drops));
        check("R9 all expected results seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule